// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serializer at the heart of a single-channel SPI master. A configuration word is loaded while the engine is stopped. It sets the word length, clock polarity, sampling phase, bit order, the level the data line rests at, an internal loopback path, and separate switches that turn off the transmitter and the receiver. A 16-bit baud reload value sets the shift clock. Each word placed in the transmit holding register is shifted out on `mosi` while `miso` (or the looped-back data) is captured. The captured word appears on `rx_data`, right-aligned.

Software-style control arrives as single-cycle pulses. `run_set` and `run_clr` move the engine between run and configuration mode. `rx_rd` acknowledges a received word. `clr_tx_ovf` and `clr_rx_ovf` clear the sticky overflow flags. Status is reported through `busy`, `tx_ovf` and `rx_ovf`.

Top module: `spi_shift_master`

## Requirements
- R1: After reset, `run`, `busy`, `sck`, `mosi`, `rx_valid`, `tx_ovf` and `rx_ovf` are all 0. The reset configuration is 8-bit words, clock idle low, sample on the leading edge, MSB first, idle level 0, loopback off, both directions on, and baud reload 0.
- R2: A `cfg_wr` pulse loads the configuration only while `run` is 0. `run_set` sets `run` and `run_clr` clears it. When both arrive in the same cycle, the clear wins.
- R3: `cfg_len_m1` holds the word length minus one. Only codes 1 to 7, 15 and 31 are accepted. Any other code leaves the word length unchanged, while the other fields still load.
- R4: Each half period of `sck` lasts (reload+1) clock cycles. A transfer of N bits keeps the engine shifting for 2·N·(reload+1) cycles. Outside a transfer, `sck` rests at the polarity value.
- R5: With `cfg_lead_sample`=1, the first bit is on `mosi` from the start of the transfer, data is sampled on each leading edge and changes on each trailing edge. With `cfg_lead_sample`=0, `mosi` holds the idle level until the first leading edge, then changes on leading edges, and data is sampled on trailing edges.
- R6: With `cfg_msb_first`=1, bit N-1 is sent first and received into bit N-1. With 0, bit 0 goes first.
- R7: Outside a transfer, `mosi` equals the configured idle level.
- R8: With loopback on, the receiver captures the bits driven on `mosi` and ignores `miso`.
- R9: With the transmitter off, `mosi` stays at the idle level for the whole transfer, but a held word still starts the transfer. With the receiver off, a finished transfer leaves `rx_data` and `rx_valid` unchanged.
- R10: `busy` is 1 from the cycle after a word enters the holding register while running, until the final `sck` edge of the last word. For one word, that is 1+2·N·(reload+1) cycles.
- R11: A received word of N<32 bits is right-aligned in `rx_data`, with bits 31..N zero.
- R12: `tx_wr` while the holding register is full sets `tx_ovf` and drops the new word. `clr_tx_ovf` clears the flag, but a new overflow in the same cycle wins.
- R13: A word that finishes while `rx_valid` is 1 and `rx_rd` is 0 sets `rx_ovf` and replaces `rx_data`. `rx_rd` clears `rx_valid`. `clr_rx_ovf` clears `rx_ovf`, with set winning over clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load configuration fields (pulse) |
| cfg_len_m1 | input | 5 | Word length minus one |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_idle | input | 1 | Data line idle level |
| cfg_lead_sample | input | 1 | 1: sample on leading edge; 0: sample on trailing edge |
| cfg_msb_first | input | 1 | Bit order |
| cfg_loop | input | 1 | Internal loopback |
| cfg_tx_off | input | 1 | Transmitter off |
| cfg_rx_off | input | 1 | Receiver off |
| cfg_baud | input | 16 | Baud reload value |
| run_set | input | 1 | Enter run mode (pulse) |
| run_clr | input | 1 | Enter configuration mode (pulse) |
| tx_data | input | 32 | Word to transmit |
| tx_wr | input | 1 | Write holding register (pulse) |
| rx_rd | input | 1 | Acknowledge received word (pulse) |
| clr_tx_ovf | input | 1 | Clear transmit overflow (pulse) |
| clr_rx_ovf | input | 1 | Clear receive overflow (pulse) |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| rx_data | output | 32 | Last received word, right-aligned |
| rx_valid | output | 1 | Received word not yet acknowledged |
| busy | output | 1 | Transfer pending or in progress |
| run | output | 1 | Run mode active |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_ovf | output | 1 | Sticky receive overflow |

## Verification
The bench aims at the phase split. An engine that sampled on the wrong edge, or that drove the first bit early when sampling on the trailing edge, would show `mosi` out of step with the reference in the first half period and would capture a word shifted by one bit.

It measures busy time at several reload values and lengths. An off-by-one divider, or a busy flag that dropped once the holding register emptied, would give the wrong count.

It also drives illegal length codes, configuration writes while running, and overflow sets that coincide with clears. A design that accepted these writes would change `sck` or the received word's width. A design that let the clear win would lose an overflow.

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
  parameter int DW  = 32,
  parameter int BRW = 16,
  localparam int WW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [WW-1:0]  cfg_len_m1,
  input  logic           cfg_cpol,
  input  logic           cfg_idle,
  input  logic           cfg_lead_sample,
  input  logic           cfg_msb_first,
  input  logic           cfg_loop,
  input  logic           cfg_tx_off,
  input  logic           cfg_rx_off,
  input  logic [BRW-1:0] cfg_baud,
  input  logic           run_set,
  input  logic           run_clr,
  input  logic [DW-1:0]  tx_data,
  input  logic           tx_wr,
  input  logic           rx_rd,
  input  logic           clr_tx_ovf,
  input  logic           clr_rx_ovf,
  input  logic           miso,
  output logic           sck,
  output logic           mosi,
  output logic [DW-1:0]  rx_data,
  output logic           rx_valid,
  output logic           busy,
  output logic           run,
  output logic           tx_ovf,
  output logic           rx_ovf
);

  function automatic logic len_ok(input logic [WW-1:0] v);
    return (v != '0 && v < WW'(8)) || v == WW'(15) || v == WW'(DW-1);
  endfunction

  logic [WW-1:0]  w_q;
  logic           cpol_q, idle_q, pha_q, msb_q, loop_q, txoff_q, rxoff_q;
  logic [BRW-1:0] br_q, div_q;
  logic           run_q, hold_full, act;
  logic [DW-1:0]  hold_q, word_q, rx_sh;
  logic [WW:0]    h_q;

  wire             tick   = act && div_q == br_q;
  wire [WW:0]      last_h = {w_q, 1'b1};
  wire [WW:0]      hm1    = h_q - (WW+1)'(1);
  wire [WW-1:0]    bidx   = pha_q ? h_q[WW:1] : hm1[WW:1];
  wire [WW-1:0]    pos    = msb_q ? w_q - bidx : bidx;
  wire             quiet  = !act || txoff_q || (!pha_q && h_q == '0);
  wire             smp    = tick && (h_q[0] != pha_q);
  wire             done   = tick && h_q == last_h;
  wire             start  = run_q && hold_full && !act;
  wire             rx_bit = loop_q ? mosi : miso;
  wire [DW-1:0]    rx_nx  = smp ? (rx_sh | (DW'(rx_bit) << pos)) : rx_sh;

  assign mosi = quiet ? idle_q : word_q[pos];
  assign sck  = act ? (cpol_q ^ h_q[0]) : cpol_q;
  assign busy = act | (run_q & hold_full);
  assign run  = run_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      w_q <= WW'(7); cpol_q <= 1'b0; idle_q <= 1'b0; pha_q <= 1'b1; msb_q <= 1'b1;
      loop_q <= 1'b0; txoff_q <= 1'b0; rxoff_q <= 1'b0; br_q <= '0;
    end else if (cfg_wr && !run_q) begin
      if (len_ok(cfg_len_m1)) w_q <= cfg_len_m1;
      cpol_q <= cfg_cpol; idle_q <= cfg_idle; pha_q <= cfg_lead_sample;
      msb_q <= cfg_msb_first; loop_q <= cfg_loop; txoff_q <= cfg_tx_off;
      rxoff_q <= cfg_rx_off; br_q <= cfg_baud;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       run_q <= 1'b0;
    else if (run_clr) run_q <= 1'b0;
    else if (run_set) run_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_q <= '0; hold_full <= 1'b0; tx_ovf <= 1'b0;
    end else begin
      if (tx_wr && !hold_full) begin
        hold_q <= tx_data; hold_full <= 1'b1;
      end else if (start) hold_full <= 1'b0;
      if (tx_wr && hold_full) tx_ovf <= 1'b1;
      else if (clr_tx_ovf)    tx_ovf <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act <= 1'b0; word_q <= '0; h_q <= '0; div_q <= '0; rx_sh <= '0;
    end else if (start) begin
      act <= 1'b1; word_q <= hold_q; h_q <= '0; div_q <= '0; rx_sh <= '0;
    end else if (act) begin
      rx_sh <= rx_nx;
      if (tick) begin
        div_q <= '0;
        if (done) act <= 1'b0;
        else      h_q <= h_q + (WW+1)'(1);
      end else div_q <= div_q + BRW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data <= '0; rx_valid <= 1'b0; rx_ovf <= 1'b0;
    end else begin
      if (done && !rxoff_q) begin
        rx_data <= rx_nx; rx_valid <= 1'b1;
      end else if (rx_rd) rx_valid <= 1'b0;
      if (done && !rxoff_q && rx_valid && !rx_rd) rx_ovf <= 1'b1;
      else if (clr_rx_ovf)                        rx_ovf <= 1'b0;
    end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable({w_q, cpol_q, idle_q, pha_q, msb_q, loop_q, txoff_q, rxoff_q, br_q})); // R2
  AST_SCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !tick && run_q) |=> $stable(sck)); // R4
  AST_TX_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && hold_full) |=> tx_ovf); // R12
  AST_RX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !clr_rx_ovf) |=> rx_ovf); // R13
  AST_BUSY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R10

endmodule

// File: tb/spi_shift_master_tb.sv
module spi_shift_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_cpol = 0, cfg_idle = 0, cfg_lead_sample = 1, cfg_msb_first = 1;
  logic cfg_loop = 0, cfg_tx_off = 0, cfg_rx_off = 0;
  logic [4:0] cfg_len_m1 = 5'd7;
  logic [15:0] cfg_baud = '0;
  logic run_set = 0, run_clr = 0, tx_wr = 0, rx_rd = 0, clr_tx_ovf = 0, clr_rx_ovf = 0, miso = 0;
  logic [31:0] tx_data = '0;
  logic sck, mosi, rx_valid, busy, run, tx_ovf, rx_ovf;
  logic [31:0] rx_data;
  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  spi_shift_master dut_i (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, a, e);
    end
  endtask

  // reference model
  int m_w, m_br, m_h, m_div;
  logic m_cpol, m_idle, m_pha, m_msb, m_loop, m_txoff, m_rxoff;
  logic m_en, m_full, m_act, m_rxv, m_txov, m_rxov;
  logic [31:0] m_hold, m_word, m_rx, m_rxd;

  function automatic logic exp_mosi();
    int b, p;
    if (!m_act || m_txoff || (!m_pha && m_h == 0)) return m_idle;
    b = m_pha ? m_h / 2 : (m_h - 1) / 2;
    p = m_msb ? m_w - b : b;
    return m_word[p];
  endfunction

  function automatic logic exp_sck();
    return m_act ? (m_cpol ^ m_h[0]) : m_cpol;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_w = 7; m_br = 0; m_h = 0; m_div = 0;
      m_cpol = 0; m_idle = 0; m_pha = 1; m_msb = 1; m_loop = 0; m_txoff = 0; m_rxoff = 0;
      m_en = 0; m_full = 0; m_act = 0; m_rxv = 0; m_txov = 0; m_rxov = 0;
      m_hold = 0; m_word = 0; m_rx = 0; m_rxd = 0;
    end else begin
      logic bt, o_full, o_act, o_en, o_rxv, fin, setr;
      int b, p;
      bt = exp_mosi(); o_full = m_full; o_act = m_act; o_en = m_en; o_rxv = m_rxv; fin = 0;
      if (m_act) begin
        if (m_div == m_br) begin
          b = m_pha ? m_h / 2 : (m_h - 1) / 2;
          p = m_msb ? m_w - b : b;
          if ((m_h % 2) == (m_pha ? 0 : 1)) m_rx[p] = m_loop ? bt : miso;
          m_div = 0;
          if (m_h == 2 * m_w + 1) begin m_act = 0; fin = 1; end
          else m_h++;
        end else m_div++;
      end
      setr = fin && !m_rxoff && o_rxv && !rx_rd;
      if (fin && !m_rxoff) begin m_rxd = m_rx; m_rxv = 1; end
      else if (rx_rd) m_rxv = 0;
      if (setr) m_rxov = 1; else if (clr_rx_ovf) m_rxov = 0;
      if (tx_wr && o_full) m_txov = 1; else if (clr_tx_ovf) m_txov = 0;
      if (tx_wr && !o_full) begin m_hold = tx_data; m_full = 1; end
      if (!o_act && o_en && o_full) begin
        m_act = 1; m_word = m_hold; m_h = 0; m_div = 0; m_rx = 0; m_full = 0;
      end
      if (cfg_wr && !o_en) begin
        if ((cfg_len_m1 >= 1 && cfg_len_m1 <= 7) || cfg_len_m1 == 15 || cfg_len_m1 == 31)
          m_w = cfg_len_m1;
        m_cpol = cfg_cpol; m_idle = cfg_idle; m_pha = cfg_lead_sample; m_msb = cfg_msb_first;
        m_loop = cfg_loop; m_txoff = cfg_tx_off; m_rxoff = cfg_rx_off; m_br = cfg_baud;
      end
      if (run_clr) m_en = 0; else if (run_set) m_en = 1;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= lfsr[15];
    if (rst_n) begin
      chk("R4", "sck vs model", sck, exp_sck());
      chk("R5", "mosi vs model", mosi, exp_mosi());
      chk("R10", "busy vs model", busy, m_act | (m_en & m_full));
      chk("R2", "run vs model", run, m_en);
      chk("R12", "tx_ovf vs model", tx_ovf, m_txov);
      chk("R13", "rx_ovf vs model", rx_ovf, m_rxov);
      chk("R9", "rx_valid vs model", rx_valid, m_rxv);
      chk("R11", "rx_data vs model", rx_data, m_rxd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog R10: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pulse_run(input bit s, input bit c);
    @(negedge clk); run_set = s; run_clr = c;
    @(negedge clk); run_set = 0; run_clr = 0;
  endtask

  task automatic setup(input int bits, input int mode, input bit lsb, input bit lp,
                       input bit toff, input bit roff, input int br);
    pulse_run(0, 1);
    cfg_wr = 1; cfg_len_m1 = 5'(bits - 1); cfg_cpol = mode[1]; cfg_idle = mode[1];
    cfg_lead_sample = ~mode[0]; cfg_msb_first = ~lsb; cfg_loop = lp;
    cfg_tx_off = toff; cfg_rx_off = roff; cfg_baud = 16'(br);
    @(negedge clk); cfg_wr = 0;
    pulse_run(1, 0);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic xfer(input logic [31:0] d, output int n);
    @(negedge clk); tx_wr = 1; tx_data = d;
    @(negedge clk); tx_wr = 0;
    wait_idle(n);
  endtask

  task automatic rd();
    rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset sck", sck, 0); chk("R1", "reset mosi", mosi, 0);
    chk("R1", "reset busy", busy, 0); chk("R1", "reset run", run, 0);
    chk("R1", "reset flags", {tx_ovf, rx_ovf, rx_valid}, 0);

    pulse_run(1, 0);
    xfer(32'h0000_00C3, n);
    chk("R1", "default 8-bit msb loop off busy len", n, 1 + 16);
    rd();

    setup(8, 0, 0, 1, 0, 0, 2);
    xfer(32'h0000_00A5, n);
    chk("R10", "busy cycles 8b br2", n, 1 + 16 * 3);
    chk("R8", "loopback word", rx_data, 32'hA5);
    chk("R7", "idle mosi low", mosi, 0);
    rd();

    setup(16, 3, 1, 1, 0, 0, 1);
    xfer(32'h1234_BEEF, n);
    chk("R4", "busy cycles 16b br1", n, 1 + 32 * 2);
    chk("R6", "lsb-first loop word", rx_data, 32'h0000_BEEF);
    chk("R7", "idle mosi high", mosi, 1);
    chk("R4", "idle sck high", sck, 1);
    rd();

    setup(5, 1, 0, 1, 0, 0, 0);
    xfer(32'hFFFF_FFFF, n);
    chk("R11", "5-bit right aligned", rx_data, 32'h1F);
    rd();

    setup(8, 2, 0, 0, 0, 0, 1);
    xfer(32'h3C, n); rd();
    setup(7, 1, 1, 0, 0, 0, 3);
    xfer(32'h55, n);
    chk("R5", "mode1 7b busy cycles", n, 1 + 14 * 4);
    rd();

    setup(32, 0, 0, 1, 0, 0, 0);
    xfer(32'hDEAD_BEEF, n);
    chk("R11", "32-bit word", rx_data, 32'hDEAD_BEEF);
    chk("R4", "32-bit busy cycles", n, 1 + 64);
    rd();

    setup(8, 3, 0, 1, 1, 0, 0);
    xfer(32'h00, n);
    chk("R9", "tx off sends idle ones", rx_data, 32'hFF);
    rd();
    setup(8, 0, 0, 1, 0, 1, 0);
    xfer(32'h11, n);
    chk("R9", "rx off keeps data", rx_data, 32'hFF);
    chk("R9", "rx off keeps valid low", rx_valid, 0);

    setup(16, 0, 0, 1, 0, 0, 0);
    setup(10, 0, 0, 1, 0, 0, 0);
    xfer(32'hFFFF_FFFF, n);
    chk("R3", "illegal length ignored", rx_data, 32'hFFFF);
    chk("R3", "illegal length busy", n, 1 + 32);
    rd();

    @(negedge clk); cfg_wr = 1; cfg_cpol = 1; cfg_len_m1 = 5'd3;
    @(negedge clk); cfg_wr = 0;
    @(negedge clk);
    chk("R2", "cfg ignored while running sck", sck, 0);
    xfer(32'hFFFF_FFFF, n);
    chk("R2", "cfg ignored while running length", rx_data, 32'hFFFF);
    rd();
    pulse_run(1, 1);
    chk("R2", "clear wins over set", run, 0);

    setup(8, 0, 0, 1, 0, 0, 0);
    pulse_run(0, 1);
    tx_wr = 1; tx_data = 32'h5A; @(negedge clk);
    tx_data = 32'h66; @(negedge clk); tx_wr = 0;
    chk("R12", "overflow set", tx_ovf, 1);
    tx_wr = 1; tx_data = 32'h77; clr_tx_ovf = 1; @(negedge clk);
    tx_wr = 0; clr_tx_ovf = 0;
    chk("R12", "set wins over clear", tx_ovf, 1);
    clr_tx_ovf = 1; @(negedge clk); clr_tx_ovf = 0;
    chk("R12", "clear", tx_ovf, 0);
    pulse_run(1, 0);
    wait_idle(n);
    chk("R12", "first word kept", rx_data, 32'h5A);
    rd();

    xfer(32'h01, n);
    xfer(32'h02, n);
    chk("R13", "rx overflow set", rx_ovf, 1);
    chk("R13", "newest word", rx_data, 32'h02);
    rd();
    chk("R13", "rx_rd clears valid", rx_valid, 0);
    clr_rx_ovf = 1; @(negedge clk); clr_rx_ovf = 0;
    chk("R13", "rx overflow clear", rx_ovf, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule